// File: doc/BRIEF.md
# Bit Clock Recovery with Stepped Phase Correction

This block rebuilds a bit clock from a serial data stream that has no clock of its own. A counter driven by the base clock runs through one nominal bit period again and again. The period length comes from a 14-bit programmable count. The recovered clock is low for the first half of each count cycle and high for the second half. Count zero is where the block expects a data transition, so the rising edge of the recovered clock falls near the middle of each bit.

The received data first passes through a synchronizer. Every change in the synchronized data is then compared with the current count:

- A transition seen early in the count cycle means the counter is running ahead of the data. The counter is pulled back by a programmable step.
- A transition seen late in the count cycle means the counter is behind the data. The counter is pushed forward by the same step.

Each transition therefore moves the phase by a bounded amount. A single noisy edge shifts the clock by a few counts only, and cannot add or drop a bit. The recovered clock runs whenever the block is enabled, even when the data input is idle.

Top module: `bitclk_recover`

## Requirements
- R1: While `rst` is high, on each clock edge the count and `rec_clk` go to 0. After `rst` falls with `en` high, the first rise of `rec_clk` is sampled H clock cycles later. P is `period_cnt`, raised to 2 if it is programmed below 2, and H = floor(P/2).
- R2: While `en` is low, the count and `rec_clk` are held at 0, whatever `data_in` does. After `en` rises, the first rise of `rec_clk` comes H cycles later.
- R3: With no data transitions, the count runs 0 to P-1 and then wraps. `rec_clk` is low for H cycles (counts 0 to H-1) and high for P-H cycles in every period.
- R4: `data_in` passes through two synchronizer flops. A change on `data_in` that is set up before clock edge t is compared against the count value loaded at edge t+1, and its correction takes effect at edge t+2.
- R5: A transition seen at count c with c >= H advances the counter: the next count is c+1+step. If that sum reaches P, the next count is 0 instead.
- R6: A transition seen at count c with 0 < c < H retards the counter: the next count is c+1-step. If step > c+1, the next count is 0 instead.
- R7: A transition seen at count 0 causes no correction. The period in which it falls keeps its nominal length P.
- R8: If the count is at or above P-1, for example after `period_cnt` is reduced, the next count is 0 and `rec_clk` drops.
- R9: With `step_cnt` = 0, data transitions have no effect on the timing of `rec_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; all logic updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables the recovered clock; low holds the count and output at 0 |
| data_in | input | 1 | Asynchronous received serial data |
| period_cnt | input | 14 | Nominal bit period in base clock cycles |
| step_cnt | input | 8 | Phase correction applied per data transition, in base clock cycles |
| rec_clk | output | 1 | Registered recovered bit clock |

## Verification
On every cycle, the assertions check the following:
- The count stays below the effective period.
- `rec_clk` agrees with the half-period threshold.
- The count never moves by more than the step plus one between cycles, except when it drops to zero.
- A zero step leaves the count advancing by exactly one.
- Disable and reset force the count and `rec_clk` to zero.

The direction of each correction and the exact size of each correction can only be shown by the bench scenarios. The same holds for the clamping at both ends of the count, the two-flop input latency and the no-correction case at count zero. The bench measures these as the spacing between rises of `rec_clk`.

// File: rtl/bitclk_recover_pkg.sv
package bitclk_recover_pkg;

  typedef enum logic [1:0] {
    CORR_NONE = 2'd0,
    CORR_ADV  = 2'd1,
    CORR_RET  = 2'd2
  } corr_e;

endpackage

// File: rtl/bitclk_sync.sv
module bitclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bitclk_edge.sv
module bitclk_edge (
  input  logic clk,
  input  logic rst,
  input  logic s,
  output logic edge_o
);
  logic last_q;

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= s;
  end

  assign edge_o = s ^ last_q;
endmodule

// File: rtl/bitclk_phase.sv
module bitclk_phase
  import bitclk_recover_pkg::*;
#(
  parameter int RATE_W = 14
) (
  input  logic              edge_i,
  input  logic [RATE_W-1:0] cnt,
  input  logic [RATE_W-1:0] half,
  output corr_e             corr
);
  always_comb begin
    corr = CORR_NONE;
    if (edge_i) begin
      if (cnt >= half)          corr = CORR_ADV;
      else if (cnt != '0)       corr = CORR_RET;
    end
  end
endmodule

// File: rtl/bitclk_counter.sv
module bitclk_counter
  import bitclk_recover_pkg::*;
#(
  parameter int RATE_W = 14,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [RATE_W-1:0] peff,
  input  logic [RATE_W-1:0] half,
  input  logic [STEP_W-1:0] step,
  input  corr_e             corr,
  output logic [RATE_W-1:0] cnt_q,
  output logic              clk_q
);
  localparam int SUM_W = ((RATE_W > STEP_W) ? RATE_W : STEP_W) + 2;

  logic [SUM_W-1:0]  c_ext, s_ext, p_ext, inc_ext;
  logic [RATE_W-1:0] cnt_nxt;

  always_comb begin
    c_ext   = SUM_W'(cnt_q);
    s_ext   = SUM_W'(step);
    p_ext   = SUM_W'(peff);
    inc_ext = c_ext + SUM_W'(1);
    unique case (corr)
      CORR_ADV: begin
        if (inc_ext + s_ext >= p_ext) cnt_nxt = '0;
        else                          cnt_nxt = RATE_W'(inc_ext + s_ext);
      end
      CORR_RET: begin
        if (s_ext > inc_ext) cnt_nxt = '0;
        else                 cnt_nxt = RATE_W'(inc_ext - s_ext);
      end
      default: begin
        if (inc_ext >= p_ext) cnt_nxt = '0;
        else                  cnt_nxt = RATE_W'(inc_ext);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      clk_q <= (cnt_nxt >= half);
    end
  end
endmodule

// File: rtl/bitclk_recover.sv
module bitclk_recover
  import bitclk_recover_pkg::*;
#(
  parameter int RATE_W      = 14,
  parameter int STEP_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              data_in,
  input  logic [RATE_W-1:0] period_cnt,
  input  logic [STEP_W-1:0] step_cnt,
  output logic              rec_clk
);
  localparam logic [RATE_W-1:0] MIN_PERIOD = RATE_W'(2);

  logic              data_s;
  logic              edge_w;
  logic [RATE_W-1:0] peff, half;
  logic [RATE_W-1:0] cnt_q;
  corr_e             corr;

  assign peff = (period_cnt < MIN_PERIOD) ? MIN_PERIOD : period_cnt;
  assign half = peff >> 1;

  bitclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d (data_in), .q (data_s)
  );

  bitclk_edge u_edge (
    .clk (clk), .rst (rst), .s (data_s), .edge_o (edge_w)
  );

  bitclk_phase #(.RATE_W(RATE_W)) u_phase (
    .edge_i (edge_w), .cnt (cnt_q), .half (half), .corr (corr)
  );

  bitclk_counter #(.RATE_W(RATE_W), .STEP_W(STEP_W)) u_cnt (
    .clk (clk), .rst (rst), .en (en), .peff (peff), .half (half),
    .step (step_cnt), .corr (corr), .cnt_q (cnt_q), .clk_q (rec_clk)
  );
endmodule

// File: rtl/bitclk_recover_chk.sv
module bitclk_recover_chk #(
  parameter int RATE_W = 14,
  parameter int STEP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [RATE_W-1:0] period_cnt,
  input logic [STEP_W-1:0] step_cnt,
  input logic [RATE_W-1:0] cnt_q,
  input logic              rec_clk
);
  int p_i;
  assign p_i = (int'(period_cnt) < 2) ? 2 : int'(period_cnt);

  // R1: reset clears count and output
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!rec_clk && cnt_q == '0));

  // R2: disabled holds everything at zero
  assert_disable_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!rec_clk && cnt_q == '0));

  // R3 and R8: count always inside the effective period
  assert_count_range_R3: assert property (@(posedge clk) disable iff (rst)
    en |=> (!$stable(period_cnt) || int'(cnt_q) < p_i));

  // R3: output level follows the half-period threshold
  assert_clock_level_R3: assert property (@(posedge clk) disable iff (rst)
    en |=> (!$stable(period_cnt) || (rec_clk == (int'(cnt_q) >= (p_i / 2)))));

  // R5 and R6: count moves by at most step+1 per cycle, except when it clamps to zero
  assert_bounded_slew_R5: assert property (@(posedge clk) disable iff (rst)
    en |=> (cnt_q == '0) ||
           ((int'(cnt_q) <= int'($past(cnt_q)) + int'($past(step_cnt)) + 1) &&
            (int'(cnt_q) + int'($past(step_cnt)) >= int'($past(cnt_q)) + 1)));

  // R9: zero step leaves plain counting
  assert_zero_step_R9: assert property (@(posedge clk) disable iff (rst)
    (en && step_cnt == '0) |=> (cnt_q == '0 || int'(cnt_q) == int'($past(cnt_q)) + 1));
endmodule

bind bitclk_recover bitclk_recover_chk #(.RATE_W(RATE_W), .STEP_W(STEP_W)) u_chk (
  .clk (clk), .rst (rst), .en (en), .period_cnt (period_cnt),
  .step_cnt (step_cnt), .cnt_q (cnt_q), .rec_clk (rec_clk)
);

// File: tb/bitclk_recover_test.sv
module bitclk_recover_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  localparam int VEC_P  [NV] = '{10, 7, 200, 1, 0, 3};
  localparam int VEC_LO [NV] = '{5, 3, 100, 1, 1, 1};
  localparam int VEC_HI [NV] = '{5, 4, 100, 1, 1, 2};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b1;
  logic        data_in = 1'b0;
  logic [13:0] period_cnt = 14'd20;
  logic [7:0]  step_cnt = 8'd3;
  logic        rec_clk;

  int checks = 0;
  int fails = 0;

  bitclk_recover uut (
    .clk (clk), .rst (rst), .en (en), .data_in (data_in),
    .period_cnt (period_cnt), .step_cnt (step_cnt), .rec_clk (rec_clk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rise(output int n);
    logic prev;
    prev = rec_clk;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (!prev && rec_clk) break;
      prev = rec_clk;
    end
  endtask

  // called at the negedge where a rise was seen; toggles data after w negedges
  task automatic gap_with_toggle(int w, output int gap);
    logic prev;
    int i;
    prev = 1'b1;
    gap = 0;
    i = 0;
    forever begin
      if (i == w) data_in = ~data_in;
      @(negedge clk);
      gap++;
      i++;
      if (!prev && rec_clk) break;
      prev = rec_clk;
    end
  endtask

  task automatic measure_levels(output int hi, output int lo);
    int n;
    wait_rise(n);
    hi = 1;
    lo = 0;
    forever begin
      @(negedge clk);
      if (!rec_clk) break;
      hi++;
    end
    forever begin
      lo++;
      @(negedge clk);
      if (rec_clk) break;
    end
  endtask

  task automatic correction_case(string req, int step, int w, int exp);
    int n, g;
    step_cnt = 8'(step);
    wait_rise(n);
    wait_rise(n);
    gap_with_toggle(w, g);
    check(req, g, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n, hi, lo;
    // R1: reset state and first rise after release
    repeat (3) @(negedge clk);
    check("R1 reset output", int'(rec_clk), 0);
    rst = 1'b0;
    wait_rise(n);
    check("R1 first rise after reset", n, 10);

    // R3: free-running waveform table, data idle
    step_cnt = 8'd0;
    for (int v = 0; v < NV; v++) begin
      period_cnt = 14'(VEC_P[v]);
      wait_rise(n);
      measure_levels(hi, lo);
      check("R3 high cycles", hi, VEC_HI[v]);
      check("R3 low cycles", lo, VEC_LO[v]);
    end

    // R4/R5/R6/R7/R9: phase corrections, P = 20, H = 10
    period_cnt = 14'd20;
    correction_case("R5 advance by step", 3, 0, 17);
    correction_case("R5 advance clamp", 50, 0, 13);
    correction_case("R6 retard by step", 3, 12, 23);
    correction_case("R6 retard clamp", 50, 12, 25);
    correction_case("R7 edge at count zero R4", 3, 8, 20);
    correction_case("R9 zero step", 0, 0, 20);

    // R2: disabled hold with data activity, then restart
    step_cnt = 8'd3;
    @(negedge clk);
    en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      data_in = ~data_in;
    end
    check("R2 output held low", int'(rec_clk), 0);
    repeat (5) @(negedge clk);
    en = 1'b1;
    n = 0;
    while (!rec_clk && n < 100) begin
      @(negedge clk);
      n++;
    end
    check("R2 first rise after enable", n, 10);

    // R8: period shrinks while count is above the new limit
    period_cnt = 14'd200;
    wait_rise(n);
    wait_rise(n);
    repeat (50) @(negedge clk);
    period_cnt = 14'd20;
    wait_rise(n);
    check("R8 wrap after shrink", n, 11);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule